// File: doc/BRIEF.md
# UART Receiver Front End with Break Detection

This block turns an asynchronous serial line into tagged receive entries. It samples the line on a 16x oversampling strobe. It confirms each start bit at mid-bit and takes every data bit at its centre, least significant bit first. It assembles 5 to 8 data bits, with or without a parity bit, and checks the stop bit. Each finished character is offered to a receive FIFO as one entry. The entry carries the data together with a framing-error flag, a parity-error flag and a break flag.

A break is a character that arrives as all zeros and has no stop bit. The block writes a single entry for it. It then refuses further entries until the line has been back at mark for half a bit time. It pulses a change event once when the break begins and once when it ends. The baud-rate strobe and the FIFO are supplied from outside.

Top module: `uart_rx_brk`

## Requirements
- R1: After reset `wr_valid`, `brk_line` and `brk_chg` are low.
- R2: A falling edge starts a character only if the line is still low on the 8th sample strobe after the edge was seen. Otherwise the receiver goes back to idle and writes no entry.
- R3: Data bits are sampled every 16 strobes after the start-bit centre and stored LSB first. `cfg_len` selects 5 + `cfg_len` data bits (0 gives 5, 3 gives 8). Unused upper bits of `wr_data` read as zero.
- R4: The stop bit is sampled at the centre of its first bit time. A low sample there sets `wr_fe` for that character.
- R5: `cfg_par` 2'b00 means no parity bit, and `wr_pe` is 0. With 2'b01 a parity bit follows the data. `wr_pe` is set when the XOR of the data bits, the parity bit and `cfg_psel` is 1 (`cfg_psel` 0 = even, 1 = odd). With 2'b10 the received parity bit must equal `cfg_psel`, and `wr_pe` is set on a mismatch.
- R6: With `cfg_par` 2'b11 (multidrop wake-up) a ninth address/data bit follows the data, and `wr_pe` carries that received bit unchanged.
- R7: A character whose data bits and parity bit (if present) are all zero and whose stop sample is low is a break. It yields one entry with `wr_brk`=1, `wr_fe`=1 and data zero. `brk_line` rises at the same edge, and `brk_chg` pulses for one clock.
- R8: While `brk_line` is high, no entry is written. The break ends after 8 consecutive sample strobes (half a bit time) that see the line high. `brk_line` then falls and `brk_chg` pulses for one clock. A shorter high stretch does not end the break.
- R9: A break that begins partway through a character gives that character `wr_fe`=1 and `wr_brk`=0. It is flagged as a break on the following character, provided the line stays low through that character.
- R10: While `wr_valid` is high and `wr_ready` is low, the entry stays unchanged. A character that completes during that time is discarded.
- R11: A one-clock `rx_reset` pulse abandons any partial character and clears `brk_line` without a `brk_chg` pulse.
- R12: While `rx_en` is low no start bit is taken and any partial character is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_en | input | 1 | Receiver enable |
| sample_en | input | 1 | 16x oversampling strobe, one clock wide |
| rxd | input | 1 | Asynchronous serial input, idle high |
| cfg_len | input | 2 | Data length code, 5 + value bits |
| cfg_par | input | 2 | Parity mode: none, checked, forced, wake-up |
| cfg_psel | input | 1 | Odd select (checked) or forced bit value |
| rx_reset | input | 1 | Receiver reset command pulse |
| wr_ready | input | 1 | FIFO can accept an entry |
| wr_valid | output | 1 | Entry offered to the FIFO |
| wr_data | output | 8 | Received data bits |
| wr_fe | output | 1 | Framing error flag |
| wr_pe | output | 1 | Parity error flag, or address/data bit in wake-up mode |
| wr_brk | output | 1 | Break flag |
| brk_line | output | 1 | Break in progress |
| brk_chg | output | 1 | One-clock pulse at break start and end |

## Verification
A bit counter or strobe counter that is off by one shows up as a shifted data byte, a wrong flag, or a missing or extra entry. These appear at the FIFO port roughly one bit time after the stop-bit centre of the affected character. A break monitor that never leaves its blocking state is seen through `brk_line` and through the next clean character, which then fails to arrive. One that leaves too early shows a second break entry or a missing `brk_chg` pulse within a few bit times. Random frames with every length and parity mode are mixed with directed glitches, mid-character breaks, short mark pulses and held-off FIFO writes.

// File: rtl/uart_rx_pkg.sv
// Shared types for the UART receive front end.
// Assumes: parity mode codes match the cfg_par encoding at the top ports.
package uart_rx_pkg;

    typedef enum logic [1:0] {
        PM_NONE  = 2'b00,
        PM_WITH  = 2'b01,
        PM_FORCE = 2'b10,
        PM_WAKE  = 2'b11
    } par_mode_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP,
        ST_MARK
    } rx_state_t;

    // Parity flag for one character; dpar is the XOR of the data bits.
    function automatic logic pe_of(par_mode_t m, logic sel, logic dpar, logic pbit);
        case (m)
            PM_WITH:  return dpar ^ pbit ^ sel;
            PM_FORCE: return pbit ^ sel;
            PM_WAKE:  return pbit;
            default:  return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/rx_sync.sv
// Multi-flop synchronizer for the asynchronous serial line.
// Assumes: STAGES >= 1; the line idles high, so the flops reset to 1.
module rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sr;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            // first flop takes the raw line
            always_ff @(posedge clk) begin
                if (!rst_n) sr[g] <= 1'b1;
                else        sr[g] <= d;
            end
        end else begin : g_next
            // later flops shift the value along
            always_ff @(posedge clk) begin
                if (!rst_n) sr[g] <= 1'b1;
                else        sr[g] <= sr[g-1];
            end
        end
    end

    assign q = sr[STAGES-1];
endmodule

// File: rtl/rx_frame.sv
// Character framer: finds and confirms the start bit, then samples the data,
// parity and stop bits at their centres. It raises fr_done for one clock at the
// stop-bit sample, with the data and flags valid in that same clock.
// Assumes: rxd is already synchronized; tick is a one-clock 16x strobe.
module rx_frame
    import uart_rx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OSR    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              rxd,
    input  logic              rx_en,
    input  logic              clr,
    input  logic              brk_active,
    input  logic [1:0]        cfg_len,
    input  logic [1:0]        cfg_par,
    input  logic              cfg_psel,
    output logic              fr_done,
    output logic [DATA_W-1:0] fr_data,
    output logic              fr_fe,
    output logic              fr_pe,
    output logic              fr_brk
);
    localparam int CW    = $clog2(OSR);
    localparam int BW    = $clog2(DATA_W);
    localparam int MID   = OSR / 2;
    localparam int MIN_W = DATA_W - 3;

    rx_state_t         state;
    logic [CW-1:0]     cnt;
    logic [BW-1:0]     bidx;
    logic [DATA_W-1:0] shreg;
    logic              parbit;

    par_mode_t pmode;
    logic      par_on, bit_end, last_bit;

    // decode configuration and the bit-centre points
    always_comb begin
        pmode    = par_mode_t'(cfg_par);
        par_on   = (pmode != PM_NONE);
        bit_end  = (cnt == CW'(OSR - 1));
        last_bit = (bidx == BW'(MIN_W - 1) + BW'(cfg_len));
    end

    // result of the stop-bit sample
    always_comb begin
        fr_done = rx_en && !clr && tick && (state == ST_STOP) && bit_end;
        fr_data = shreg;
        fr_fe   = !rxd;
        fr_pe   = pe_of(pmode, cfg_psel, ^shreg, parbit);
        fr_brk  = (shreg == '0) && !(par_on && parbit) && !rxd;
    end

    // frame state machine, advanced on sample strobes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            cnt    <= '0;
            bidx   <= '0;
            shreg  <= '0;
            parbit <= 1'b0;
        end else if (clr || !rx_en) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else if (tick) begin
            case (state)
                ST_IDLE: begin
                    if (brk_active) begin
                        state <= ST_MARK;
                    end else if (!rxd) begin
                        state <= ST_START;
                        cnt   <= '0;
                    end
                end
                ST_START: begin
                    if (cnt == CW'(MID - 1)) begin
                        cnt <= '0;
                        if (rxd) begin
                            state <= ST_IDLE;
                        end else begin
                            state  <= ST_DATA;
                            bidx   <= '0;
                            shreg  <= '0;
                            parbit <= 1'b0;
                        end
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_DATA: begin
                    if (bit_end) begin
                        cnt         <= '0;
                        shreg[bidx] <= rxd;
                        if (last_bit) state <= par_on ? ST_PAR : ST_STOP;
                        else          bidx  <= bidx + 1'b1;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_PAR: begin
                    if (bit_end) begin
                        cnt    <= '0;
                        parbit <= rxd;
                        state  <= ST_STOP;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_STOP: begin
                    if (bit_end) begin
                        cnt   <= '0;
                        state <= fr_brk ? ST_MARK : ST_IDLE;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_MARK: begin
                    if (!brk_active) state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    AST_GLITCH_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_en && !clr && tick && state == ST_START && cnt == CW'(MID - 1) && rxd)
        |=> state == ST_IDLE); // R2

    AST_DISABLED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> state == ST_IDLE); // R12
endmodule

// File: rtl/rx_brkmon.sv
// Break monitor: holds the break state from the break character until the line
// has been high for half a bit time, and pulses chg at both transitions.
// Assumes: set arrives only while inactive; clr wins over everything.
module rx_brkmon #(
    parameter int OSR = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic rxd,
    input  logic set,
    input  logic clr,
    output logic active,
    output logic chg
);
    localparam int MID = OSR / 2;
    localparam int HW  = $clog2(MID);

    logic [HW-1:0] hi_cnt;

    // break state and count of consecutive mark samples
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            active <= 1'b0;
            hi_cnt <= '0;
            chg    <= 1'b0;
        end else begin
            chg <= 1'b0;
            if (set) begin
                active <= 1'b1;
                hi_cnt <= '0;
                chg    <= 1'b1;
            end else if (active && tick) begin
                if (!rxd) begin
                    hi_cnt <= '0;
                end else if (hi_cnt == HW'(MID - 1)) begin
                    active <= 1'b0;
                    hi_cnt <= '0;
                    chg    <= 1'b1;
                end else begin
                    hi_cnt <= hi_cnt + 1'b1;
                end
            end
        end
    end

    AST_CHG_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        ((active != $past(active)) && !$past(clr)) |-> chg); // R8

    AST_CHG_ONLY_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        chg |-> (active != $past(active))); // R7
endmodule

// File: rtl/uart_rx_brk.sv
// UART receive front end: synchronizer, framer and break monitor feeding a
// one-entry write register toward a receive FIFO.
// Assumes: sample_en is a one-clock 16x strobe; the FIFO takes an entry in any
// cycle where wr_valid and wr_ready are both high.
module uart_rx_brk
    import uart_rx_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int OSR         = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_en,
    input  logic              sample_en,
    input  logic              rxd,
    input  logic [1:0]        cfg_len,
    input  logic [1:0]        cfg_par,
    input  logic              cfg_psel,
    input  logic              rx_reset,
    input  logic              wr_ready,
    output logic              wr_valid,
    output logic [DATA_W-1:0] wr_data,
    output logic              wr_fe,
    output logic              wr_pe,
    output logic              wr_brk,
    output logic              brk_line,
    output logic              brk_chg
);
    logic              rxd_s;
    logic              fr_done, fr_fe, fr_pe, fr_brk;
    logic [DATA_W-1:0] fr_data;
    logic              brk_active, brk_set, load;

    rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(rxd), .q(rxd_s)
    );

    rx_frame #(.DATA_W(DATA_W), .OSR(OSR)) u_frame (
        .clk(clk), .rst_n(rst_n), .tick(sample_en), .rxd(rxd_s),
        .rx_en(rx_en), .clr(rx_reset), .brk_active(brk_active),
        .cfg_len(cfg_len), .cfg_par(cfg_par), .cfg_psel(cfg_psel),
        .fr_done(fr_done), .fr_data(fr_data), .fr_fe(fr_fe),
        .fr_pe(fr_pe), .fr_brk(fr_brk)
    );

    rx_brkmon #(.OSR(OSR)) u_brk (
        .clk(clk), .rst_n(rst_n), .tick(sample_en), .rxd(rxd_s),
        .set(brk_set), .clr(rx_reset), .active(brk_active), .chg(brk_chg)
    );

    // a break character opens the break; no entry is written while it holds
    always_comb begin
        load    = fr_done && !brk_active;
        brk_set = load && fr_brk;
    end

    assign brk_line = brk_active;

    // one-entry write register with valid/ready toward the FIFO
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_valid <= 1'b0;
            wr_data  <= '0;
            wr_fe    <= 1'b0;
            wr_pe    <= 1'b0;
            wr_brk   <= 1'b0;
        end else if (load && (!wr_valid || wr_ready)) begin
            wr_valid <= 1'b1;
            wr_data  <= fr_data;
            wr_fe    <= fr_fe;
            wr_pe    <= fr_pe;
            wr_brk   <= fr_brk;
        end else if (wr_ready) begin
            wr_valid <= 1'b0;
        end
    end

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_data) && $stable(wr_brk)
                                     && $stable(wr_fe) && $stable(wr_pe))); // R10

    AST_BRK_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_brk) |-> (wr_fe && wr_data == '0)); // R7

    AST_NO_ENTRY_IN_BRK: assert property (@(posedge clk) disable iff (!rst_n)
        (brk_line && $past(brk_line)) |-> !(wr_valid && !$past(wr_valid))); // R8

    AST_CMD_CLEARS_BRK: assert property (@(posedge clk) disable iff (!rst_n)
        rx_reset |=> (!brk_line && !brk_chg)); // R11
endmodule

// File: tb/sim_uart_rx_brk.sv
module sim_uart_rx_brk;
    localparam int BITCLK = 64;   // 16 strobes, one every 4 clocks

    logic       clk = 1'b0;
    logic       rst_n, rx_en, sample_en, rxd, cfg_psel, rx_reset, wr_ready;
    logic [1:0] cfg_len, cfg_par;
    logic       wr_valid, wr_fe, wr_pe, wr_brk, brk_line, brk_chg;
    logic [7:0] wr_data;

    int n_chk = 0;
    int n_fail = 0;
    int chg_cnt = 0;
    logic [10:0] q[$];
    logic [1:0]  tdiv = 2'd0;

    uart_rx_brk u0 (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .sample_en(sample_en), .rxd(rxd),
        .cfg_len(cfg_len), .cfg_par(cfg_par), .cfg_psel(cfg_psel),
        .rx_reset(rx_reset), .wr_ready(wr_ready), .wr_valid(wr_valid),
        .wr_data(wr_data), .wr_fe(wr_fe), .wr_pe(wr_pe), .wr_brk(wr_brk),
        .brk_line(brk_line), .brk_chg(brk_chg)
    );

    always #10 clk = ~clk;

    // strobe generator, one clock in four
    initial sample_en = 1'b0;
    always @(negedge clk) begin
        tdiv      <= tdiv + 2'd1;
        sample_en <= (tdiv == 2'd3);
    end

    // FIFO-side monitor: collect accepted entries and break-change pulses
    always @(negedge clk) begin
        if (rst_n) begin
            if (wr_valid && wr_ready) q.push_back({wr_brk, wr_fe, wr_pe, wr_data});
            if (brk_chg) chg_cnt++;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [10:0] exp_entry(input logic [7:0] d, input logic [1:0] lenc,
                                              input logic [1:0] par, input logic psel,
                                              input logic pbit, input logic stopb);
        logic [7:0] m;
        logic pe, brk;
        m = d & 8'((9'd1 << (5 + lenc)) - 9'd1);
        case (par)
            2'b01:   pe = (^m) ^ pbit ^ psel;
            2'b10:   pe = pbit ^ psel;
            2'b11:   pe = pbit;
            default: pe = 1'b0;
        endcase
        brk = (m == 8'd0) && !(par != 2'b00 && pbit) && !stopb;
        return {brk, !stopb, pe, m};
    endfunction

    // one character; a low stop bit is held 12 strobes, then the line idles high
    task automatic send_frame(input logic [7:0] d, input logic [1:0] lenc, input logic [1:0] par,
                              input logic pbit, input logic stopb);
        rxd = 1'b0; wclk(BITCLK);
        for (int i = 0; i < 5 + int'(lenc); i++) begin
            rxd = d[i]; wclk(BITCLK);
        end
        if (par != 2'b00) begin
            rxd = pbit; wclk(BITCLK);
        end
        if (stopb) begin
            rxd = 1'b1; wclk(BITCLK);
        end else begin
            rxd = 1'b0; wclk(48);
        end
        rxd = 1'b1; wclk(2 * BITCLK);
    endtask

    task automatic expect_one(input string tag, input logic [10:0] e);
        logic [10:0] got;
        chk(tag, q.size(), 1);
        if (q.size() > 0) begin
            got = q.pop_front();
            chk(tag, int'(got), int'(e));
        end
        q.delete();
    endtask

    task automatic pulse_reset();
        rx_reset = 1'b1; wclk(1); rx_reset = 1'b0;
    endtask

    // watchdog: a hung run counts as a failure and still reports
    initial begin
        wclk(190000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [7:0]  d;
        logic [1:0]  lenc, par;
        logic        psel, pbit, stopb;
        logic [10:0] e;
        int          c0;
        void'($urandom(32'd2718));
        rst_n = 1'b0; rxd = 1'b1; rx_en = 1'b1; rx_reset = 1'b0; wr_ready = 1'b1;
        cfg_len = 2'd3; cfg_par = 2'b00; cfg_psel = 1'b0;
        wclk(6);
        rst_n = 1'b1;
        wclk(2);
        chk("R1 valid", wr_valid, 0);
        chk("R1 brk_line", brk_line, 0);
        chk("R1 brk_chg", brk_chg, 0);

        // R2: short low pulse is a glitch
        rxd = 1'b0; wclk(16); rxd = 1'b1; wclk(3 * BITCLK);
        chk("R2 glitch no entry", q.size(), 0);

        // R3: LSB-first, 5-bit length masks upper bits
        cfg_len = 2'd0;
        send_frame(8'h35, 2'd0, 2'b00, 1'b0, 1'b1);
        expect_one("R3 len5", 11'h015);
        cfg_len = 2'd3;
        send_frame(8'h01, 2'd3, 2'b00, 1'b0, 1'b1);
        expect_one("R3 lsb first", 11'h001);

        // R4: framing error on low stop sample
        send_frame(8'hA5, 2'd3, 2'b00, 1'b0, 1'b0);
        expect_one("R4 fe", 11'h2A5);

        // R6: wake-up bit carried in the parity flag
        cfg_par = 2'b11;
        send_frame(8'h42, 2'd3, 2'b11, 1'b1, 1'b1);
        expect_one("R6 wake bit", 11'h142);
        cfg_par = 2'b00;

        // random frames over all lengths and parity modes (R3 R4 R5 R6 R7)
        for (int k = 0; k < 40; k++) begin
            lenc  = 2'($urandom % 4);
            par   = 2'($urandom % 4);
            psel  = 1'($urandom % 2);
            d     = 8'($urandom);
            stopb = ($urandom % 5) != 0;
            case (par)
                2'b01:   pbit = (^(d & 8'((9'd1 << (5 + lenc)) - 9'd1))) ^ psel ^ (($urandom % 4) == 0);
                2'b10:   pbit = psel ^ (($urandom % 4) == 0);
                default: pbit = 1'($urandom % 2);
            endcase
            if (k % 7 == 3) begin
                d = 8'h00; pbit = 1'b0; stopb = 1'b0;
            end
            cfg_len = lenc; cfg_par = par; cfg_psel = psel;
            e  = exp_entry(d, lenc, par, psel, pbit, stopb);
            c0 = chg_cnt;
            send_frame(d, lenc, par, pbit, stopb);
            expect_one("R5 random frame", e);
            chk("R7 random chg count", chg_cnt - c0, e[10] ? 2 : 0);
            chk("R8 random break ended", brk_line, 0);
        end
        cfg_len = 2'd3; cfg_par = 2'b00; cfg_psel = 1'b0;

        // R7/R8: long break gives one entry; short mark does not end it
        c0 = chg_cnt;
        rxd = 1'b0; wclk(25 * BITCLK);
        chk("R7 break entries", q.size(), 1);
        if (q.size() > 0) chk("R7 break entry", int'(q.pop_front()), 'h600);
        chk("R7 break line", brk_line, 1);
        chk("R7 chg at start", chg_cnt - c0, 1);
        rxd = 1'b1; wclk(12); rxd = 1'b0; wclk(2 * BITCLK);
        chk("R8 short mark keeps break", brk_line, 1);
        chk("R8 blocked entries", q.size(), 0);
        rxd = 1'b1; wclk(2 * BITCLK);
        chk("R8 break end", brk_line, 0);
        chk("R8 chg at end", chg_cnt - c0, 2);
        send_frame(8'h5A, 2'd3, 2'b00, 1'b0, 1'b1);
        expect_one("R8 resume after break", 11'h05A);

        // R9: break starting mid-character
        c0 = chg_cnt;
        rxd = 1'b0; wclk(BITCLK);
        rxd = 1'b1; wclk(4 * BITCLK);
        rxd = 1'b0; wclk(30 * BITCLK);
        chk("R9 two entries", q.size(), 2);
        if (q.size() > 1) begin
            chk("R9 cut char", int'(q.pop_front()), 'h20F);
            chk("R9 next is break", int'(q.pop_front()), 'h600);
        end
        q.delete();
        rxd = 1'b1; wclk(2 * BITCLK);
        chk("R9 chg pulses", chg_cnt - c0, 2);

        // R11: command clears break without a change pulse
        rxd = 1'b0; wclk(25 * BITCLK);
        q.delete();
        c0 = chg_cnt;
        chk("R11 break before cmd", brk_line, 1);
        rxd = 1'b1; wclk(1);
        pulse_reset();
        wclk(2 * BITCLK);
        chk("R11 break cleared", brk_line, 0);
        chk("R11 no chg pulse", chg_cnt - c0, 0);
        chk("R11 no entry", q.size(), 0);
        // R11: partial character abandoned
        rxd = 1'b0; wclk(BITCLK + 2 * BITCLK + 20);
        pulse_reset();
        rxd = 1'b1; wclk(12 * BITCLK);
        chk("R11 partial dropped", q.size(), 0);

        // R12: receiver disabled
        rx_en = 1'b0;
        send_frame(8'h3C, 2'd3, 2'b00, 1'b0, 1'b1);
        chk("R12 disabled no entry", q.size(), 0);
        rx_en = 1'b1; wclk(4);
        send_frame(8'h3C, 2'd3, 2'b00, 1'b0, 1'b1);
        expect_one("R12 enabled again", 11'h03C);

        // R10: entry held while FIFO not ready; second character dropped
        wr_ready = 1'b0;
        send_frame(8'hC3, 2'd3, 2'b00, 1'b0, 1'b1);
        chk("R10 valid held", wr_valid, 1);
        chk("R10 data held", wr_data, 'hC3);
        send_frame(8'h99, 2'd3, 2'b00, 1'b0, 1'b1);
        chk("R10 still first entry", wr_data, 'hC3);
        wr_ready = 1'b1; wclk(4);
        expect_one("R10 accepted entry", 11'h0C3);
        chk("R10 valid cleared", wr_valid, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule